// File: doc/BRIEF.md
# Restartable Long Move/Compare Engine

This block copies one byte string onto another or compares two byte strings, one byte at a time, over a byte-wide memory port. Each string is described by an address and a 24-bit byte count. The destination pair and the source pair are loaded when a start pulse arrives in the idle state. A pad byte stands in for any byte of the shorter string. In move mode the destination count sets how many bytes are written. In compare mode the longer count sets how far the comparison can run.

The engine can be stopped between any two byte operations by an interrupt request, or by a fault reported on a memory response. When it stops, its live address and count outputs describe exactly the work still to do. A caller resumes by issuing a new start with those four values, and no byte already processed is fetched a second time. Operands may begin at any byte address.

The memory port carries one access at a time. The request side is valid/ready: while `req_valid` is high and `req_ready` is low, the engine holds the address, write flag and write data steady, and the whole operation stalls. The response side is valid/ready as well: `rsp_ready` is high only while the engine waits for the answer to its single outstanding request, so the responder may hold a response back as long as it needs.

Top module: `lmc_engine`

## Requirements
- R1: In move mode (mode=0) the engine writes dst_len bytes starting at dst_addr. The first min(dst_len, src_len) bytes come from the source and the rest are the pad byte, so a pad of zero with src_len=0 zero-fills. When the source is longer, its extra bytes are left unread and the destination memory past dst_len is left untouched. Any byte alignment is allowed.
- R2: On normal completion (end_kind=1) of a move, dst_addr has advanced by the original dst_len and dst_len is 0. src_addr has advanced by the number of source bytes read, and src_len is reduced by the same amount.
- R3: In compare mode (mode=1) the shorter operand is extended with the pad byte, and bytes are compared unsigned. On completion, cmp_res is 0 when all bytes are equal, 1 when the first differing destination byte is lower than the source byte, and 2 when it is higher. On a difference, both address/count pairs point at the differing byte.
- R4: When both counts are zero at start, end_valid rises two cycles after the start cycle with end_kind=1 and cmp_res=0, and no memory request is made.
- R5: irq is sampled only after a whole byte completes: after the write in move mode, or after an equal comparison. If irq is high then and bytes remain, the engine stops with end_kind=2 and the registers count exactly the completed bytes.
- R6: Restarting with the four reported register values finishes the operation with the same memory result as an uninterrupted run, and each source byte is read exactly once across both runs.
- R7: A response with rsp_fault high stops the engine with end_kind=3, and fault_addr is set to that access's address. The registers point at the faulting byte, and all earlier bytes have completed.
- R8: At most one access is outstanding: rsp_ready and req_valid are never high together. A request that is not yet accepted keeps its address, write flag and data stable. Back-pressure on req_ready only delays the operation; the number of accesses stays the same.
- R9: end_valid is a one-cycle pulse at the end of each operation. end_kind (0 none, 1 done, 2 interrupted, 3 fault), cmp_res and fault_addr hold their values until the next start. busy is high from the cycle after start until the end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| mode | input | 1 | 0 move, 1 compare |
| pad | input | 8 | Pad byte for the shorter operand |
| dst_addr_in | input | AW | Destination address loaded at start |
| dst_len_in | input | LW | Destination byte count loaded at start |
| src_addr_in | input | AW | Source address loaded at start |
| src_len_in | input | LW | Source byte count loaded at start |
| irq | input | 1 | Interrupt request, sampled between bytes |
| busy | output | 1 | Operation in progress |
| dst_addr | output | AW | Live destination address |
| dst_len | output | LW | Live destination count |
| src_addr | output | AW | Live source address |
| src_len | output | LW | Live source count |
| end_valid | output | 1 | One-cycle end pulse |
| end_kind | output | 2 | 0 none, 1 done, 2 interrupted, 3 fault |
| cmp_res | output | 2 | 0 equal, 1 destination low, 2 destination high |
| fault_addr | output | AW | Address of the faulting access |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | AW | Memory byte address |
| req_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | Memory response valid |
| rsp_ready | output | 1 | Engine waiting for a response |
| rsp_rdata | input | 8 | Read data |
| rsp_fault | input | 1 | Access fault on this response |

## Verification
Moves are run with a short source, so that padding starts partway through. They are also run with a long source, which shows that copying stops at the destination count, and with an empty source and zero pad, which is a pure fill. All of these use odd start addresses and a stalling request port. Compares are run with strings that differ only in the padded tail, with a difference inside the common part, and with a difference against the pad. This separates the equal, low and high codes and shows where the registers stop. An interrupt after a fixed number of writes, followed by a resume, is checked by per-address read counts. A write fault in mid-string shows where the registers stop and which bytes are left unwritten.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_DONE  = 2'd1,
    END_INTR  = 2'd2,
    END_FAULT = 2'd3
  } end_kind_e;

  typedef enum logic [1:0] {
    CMP_EQ   = 2'd0,
    CMP_LOW  = 2'd1,
    CMP_HIGH = 2'd2
  } cmp_res_e;

  typedef enum logic [1:0] {
    ACC_RD_DST = 2'd0,
    ACC_RD_SRC = 2'd1,
    ACC_WR_DST = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_STEP = 3'd1,
    ST_REQ  = 3'd2,
    ST_RSP  = 3'd3,
    ST_CMP  = 3'd4,
    ST_ADV  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/lmc_operand.sv
module lmc_operand #(
  parameter int AW = 32,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [LW-1:0] len_in,
  input  logic          adv,
  output logic [AW-1:0] addr_q,
  output logic [LW-1:0] len_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      len_q  <= len_in;
    end else if (adv && (len_q != '0)) begin
      addr_q <= addr_q + AW'(1);
      len_q  <= len_q - LW'(1);
    end
  end
endmodule

// File: rtl/lmc_seq.sv
module lmc_seq
  import lmc_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [7:0]    pad,
  input  logic          irq,
  input  logic [AW-1:0] a_addr,
  input  logic [LW-1:0] a_len,
  input  logic [AW-1:0] b_addr,
  input  logic [LW-1:0] b_len,
  output logic          load,
  output logic          adv,
  output logic          busy,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_wdata,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [7:0]    rsp_rdata,
  input  logic          rsp_fault,
  output logic          end_valid,
  output logic [1:0]    end_kind,
  output logic [1:0]    cmp_res,
  output logic [AW-1:0] fault_addr
);
  seq_state_e st;
  acc_kind_e  acc;
  logic [7:0] byte_a, byte_b, pad_q;
  logic       mode_q;
  logic       a_nz, b_nz, more_left;

  assign a_nz = (a_len != '0);
  assign b_nz = (b_len != '0);
  // Work left once the current byte is retired.
  assign more_left = (a_len > LW'(1)) || (mode_q && (b_len > LW'(1)));

  assign load      = (st == ST_IDLE) && start;
  assign adv       = (st == ST_ADV);
  assign busy      = (st != ST_IDLE);
  assign req_valid = (st == ST_REQ);
  assign rsp_ready = (st == ST_RSP);
  assign req_write = (acc == ACC_WR_DST);
  assign req_addr  = (acc == ACC_RD_SRC) ? b_addr : a_addr;
  assign req_wdata = byte_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      acc        <= ACC_RD_DST;
      byte_a     <= '0;
      byte_b     <= '0;
      pad_q      <= '0;
      mode_q     <= 1'b0;
      end_valid  <= 1'b0;
      end_kind   <= END_NONE;
      cmp_res    <= CMP_EQ;
      fault_addr <= '0;
    end else begin
      end_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          mode_q   <= mode;
          pad_q    <= pad;
          end_kind <= END_NONE;
          cmp_res  <= CMP_EQ;
          st       <= ST_STEP;
        end
        ST_STEP: begin
          if (!mode_q) begin
            if (!a_nz) begin
              st <= ST_IDLE; end_valid <= 1'b1; end_kind <= END_DONE;
            end else if (b_nz) begin
              acc <= ACC_RD_SRC; st <= ST_REQ;
            end else begin
              byte_b <= pad_q; acc <= ACC_WR_DST; st <= ST_REQ;
            end
          end else begin
            if (!a_nz && !b_nz) begin
              st <= ST_IDLE; end_valid <= 1'b1; end_kind <= END_DONE;
            end else if (a_nz) begin
              acc <= ACC_RD_DST; st <= ST_REQ;
            end else begin
              byte_a <= pad_q; acc <= ACC_RD_SRC; st <= ST_REQ;
            end
          end
        end
        ST_REQ: if (req_ready) st <= ST_RSP;
        ST_RSP: if (rsp_valid) begin
          if (rsp_fault) begin
            fault_addr <= req_addr;
            st <= ST_IDLE; end_valid <= 1'b1; end_kind <= END_FAULT;
          end else begin
            case (acc)
              ACC_RD_DST: begin
                byte_a <= rsp_rdata;
                if (b_nz) begin
                  acc <= ACC_RD_SRC; st <= ST_REQ;
                end else begin
                  byte_b <= pad_q; st <= ST_CMP;
                end
              end
              ACC_RD_SRC: begin
                byte_b <= rsp_rdata;
                if (mode_q) st <= ST_CMP;
                else begin
                  acc <= ACC_WR_DST; st <= ST_REQ;
                end
              end
              default: st <= ST_ADV;
            endcase
          end
        end
        ST_CMP: begin
          if (byte_a != byte_b) begin
            cmp_res <= (byte_a < byte_b) ? CMP_LOW : CMP_HIGH;
            st <= ST_IDLE; end_valid <= 1'b1; end_kind <= END_DONE;
          end else begin
            st <= ST_ADV;
          end
        end
        ST_ADV: begin
          if (irq && more_left) begin
            st <= ST_IDLE; end_valid <= 1'b1; end_kind <= END_INTR;
          end else begin
            st <= ST_STEP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lmc_engine.sv
module lmc_engine #(
  parameter int AW = 32,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [7:0]    pad,
  input  logic [AW-1:0] dst_addr_in,
  input  logic [LW-1:0] dst_len_in,
  input  logic [AW-1:0] src_addr_in,
  input  logic [LW-1:0] src_len_in,
  input  logic          irq,
  output logic          busy,
  output logic [AW-1:0] dst_addr,
  output logic [LW-1:0] dst_len,
  output logic [AW-1:0] src_addr,
  output logic [LW-1:0] src_len,
  output logic          end_valid,
  output logic [1:0]    end_kind,
  output logic [1:0]    cmp_res,
  output logic [AW-1:0] fault_addr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_wdata,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [7:0]    rsp_rdata,
  input  logic          rsp_fault
);
  localparam int NOPS = 2;

  logic          load, adv;
  logic [AW-1:0] op_addr_in [NOPS];
  logic [LW-1:0] op_len_in  [NOPS];
  logic [AW-1:0] op_addr    [NOPS];
  logic [LW-1:0] op_len     [NOPS];

  assign op_addr_in[0] = dst_addr_in;
  assign op_len_in[0]  = dst_len_in;
  assign op_addr_in[1] = src_addr_in;
  assign op_len_in[1]  = src_len_in;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    lmc_operand #(.AW(AW), .LW(LW)) u_op (
      .clk(clk), .rst_n(rst_n), .load(load),
      .addr_in(op_addr_in[g]), .len_in(op_len_in[g]), .adv(adv),
      .addr_q(op_addr[g]), .len_q(op_len[g])
    );
  end

  assign dst_addr = op_addr[0];
  assign dst_len  = op_len[0];
  assign src_addr = op_addr[1];
  assign src_len  = op_len[1];

  lmc_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pad(pad), .irq(irq),
    .a_addr(op_addr[0]), .a_len(op_len[0]), .b_addr(op_addr[1]), .b_len(op_len[1]),
    .load(load), .adv(adv), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault),
    .end_valid(end_valid), .end_kind(end_kind), .cmp_res(cmp_res),
    .fault_addr(fault_addr)
  );
endmodule

// File: rtl/lmc_engine_chk.sv
module lmc_engine_chk #(
  parameter int AW = 32,
  parameter int LW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] dst_len_in,
  input logic [LW-1:0] src_len_in,
  input logic          busy,
  input logic [AW-1:0] dst_addr,
  input logic [LW-1:0] dst_len,
  input logic [AW-1:0] src_addr,
  input logic [LW-1:0] src_len,
  input logic          end_valid,
  input logic [1:0]    end_kind,
  input logic [AW-1:0] fault_addr,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_ready
);
  logic [AW-1:0] dst_end, src_end;
  assign dst_end = dst_addr + AW'(dst_len);
  assign src_end = src_addr + AW'(src_len);

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

  // R5
  dst_span_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (dst_end == $past(dst_end)) && (dst_len <= $past(dst_len)));

  // R5
  src_span_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (src_end == $past(src_end)) && (src_len <= $past(src_len)));

  // R4
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dst_len_in == '0 && src_len_in == '0)
      |=> (!req_valid ##1 (end_valid && end_kind == 2'd1)));

  // R7
  fault_points_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_kind == 2'd3) |-> (fault_addr == dst_addr || fault_addr == src_addr));

  // R9
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_valid |-> (!busy && end_kind != 2'd0) ##1 !end_valid);
endmodule

bind lmc_engine lmc_engine_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dst_len_in(dst_len_in),
  .src_len_in(src_len_in), .busy(busy), .dst_addr(dst_addr), .dst_len(dst_len),
  .src_addr(src_addr), .src_len(src_len), .end_valid(end_valid),
  .end_kind(end_kind), .fault_addr(fault_addr), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .rsp_ready(rsp_ready)
);

// File: tb/lmc_engine_bench.sv
module lmc_engine_bench;
  localparam int AW = 32;
  localparam int LW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, mode = 1'b0;
  logic [7:0]    pad = '0;
  logic [AW-1:0] dst_addr_in = '0, src_addr_in = '0;
  logic [LW-1:0] dst_len_in = '0, src_len_in = '0;
  logic          irq = 1'b0;
  logic          busy, end_valid, req_valid, req_write, rsp_ready;
  logic [AW-1:0] dst_addr, src_addr, fault_addr, req_addr;
  logic [LW-1:0] dst_len, src_len;
  logic [1:0]    end_kind, cmp_res;
  logic [7:0]    req_wdata;
  logic          req_ready = 1'b1, rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [7:0]    rsp_rdata = '0;

  lmc_engine #(.AW(AW), .LW(LW)) u_lmc_engine (.*);

  always #2 clk = ~clk;

  logic [7:0]  mem   [0:1023];
  int unsigned rdcnt [0:1023];
  int unsigned req_total = 0, wr_total = 0;
  logic        stall_en = 1'b0, fault_en = 1'b0, irq_en = 1'b0;
  logic [9:0]  fault_at = '0;
  int unsigned irq_after = 0;
  int          errors = 0, checks = 0;
  int unsigned cycles = 0;
  logic        hung = 1'b0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory responder: one response per accepted request, all driving at negedge.
  initial begin
    logic p_req = 1'b0, p_rsp = 1'b0, p_wr = 1'b0;
    logic [9:0] p_a = '0;
    logic [7:0] p_d = '0;
    forever begin
      @(negedge clk);
      if (p_rsp) begin rsp_valid = 1'b0; rsp_fault = 1'b0; end
      if (p_req) begin
        req_total++;
        rsp_fault = fault_en && (p_a == fault_at);
        if (!rsp_fault) begin
          if (p_wr) begin mem[p_a] = p_d; wr_total++; end
          else begin rsp_rdata = mem[p_a]; rdcnt[p_a]++; end
        end
        rsp_valid = 1'b1;
      end
      irq = irq_en && (wr_total >= irq_after);
      req_ready = stall_en ? ~req_ready : 1'b1;
      p_rsp = rsp_valid && rsp_ready;
      p_req = req_valid && req_ready;
      p_wr = req_write; p_a = req_addr[9:0]; p_d = req_wdata;
    end
  end

  task automatic run_op(input logic m, input logic [7:0] p, input int da, input int dl,
                        input int sa, input int sl);
    @(negedge clk);
    mode = m; pad = p;
    dst_addr_in = AW'(da); dst_len_in = LW'(dl);
    src_addr_in = AW'(sa); src_len_in = LW'(sl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!end_valid && !hung) @(negedge clk);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 1024; i++) rdcnt[i] = 0;
    req_total = 0; wr_total = 0;
  endtask

  task automatic t_reset();
    check("R9 reset busy", busy, 0);
    check("R9 reset end_kind", end_kind, 0);
    check("R8 reset req_valid", req_valid, 0);
  endtask

  task automatic t_move_pad();
    for (int i = 0; i < 16; i++) mem[10'h200 + i] = 8'h11;
    for (int i = 0; i < 5; i++) mem[10'h101 + i] = 8'h30 + 8'(i);
    clear_counts();
    stall_en = 1'b1;
    run_op(1'b0, 8'hA5, 'h203, 8, 'h101, 5);
    stall_en = 1'b0;
    check("R1 end_kind", end_kind, 1);
    for (int i = 0; i < 5; i++) check("R1 copied byte", mem[10'h203 + i], 8'h30 + i);
    for (int i = 5; i < 8; i++) check("R1 pad byte", mem[10'h203 + i], 8'hA5);
    check("R1 past end untouched", mem[10'h20B], 8'h11);
    check("R2 dst_addr", dst_addr, 'h20B);
    check("R2 dst_len", dst_len, 0);
    check("R2 src_addr", src_addr, 'h106);
    check("R2 src_len", src_len, 0);
    check("R8 access count under stall", req_total, 13);
    @(negedge clk);
    check("R9 end_valid one cycle", end_valid, 0);
    check("R9 end_kind held", end_kind, 1);
  endtask

  task automatic t_move_long_src();
    for (int i = 0; i < 8; i++) mem[10'h250 + i] = 8'h00;
    for (int i = 0; i < 6; i++) mem[10'h150 + i] = 8'h60 + 8'(i);
    clear_counts();
    run_op(1'b0, 8'hFF, 'h250, 3, 'h150, 6);
    check("R1 long src byte2", mem[10'h252], 8'h62);
    check("R1 long src stop", mem[10'h253], 8'h00);
    check("R1 extra src unread", rdcnt[10'h153], 0);
    check("R2 src_addr remainder", src_addr, 'h153);
    check("R2 src_len remainder", src_len, 3);
  endtask

  task automatic t_zero_fill();
    for (int i = 0; i < 5; i++) mem[10'h2E1 + i] = 8'hFF;
    run_op(1'b0, 8'h00, 'h2E1, 4, 'h0, 0);
    for (int i = 0; i < 4; i++) check("R1 zero fill", mem[10'h2E1 + i], 0);
    check("R1 zero fill bound", mem[10'h2E5], 8'hFF);
  endtask

  task automatic t_zero_len();
    clear_counts();
    run_op(1'b1, 8'h00, 'h10, 0, 'h20, 0);
    check("R4 end_kind", end_kind, 1);
    check("R4 cmp_res equal", cmp_res, 0);
    check("R4 no access", req_total, 0);
  endtask

  task automatic t_compare();
    mem[10'h300] = 8'h41; mem[10'h301] = 8'h42; mem[10'h302] = 8'h43;
    mem[10'h303] = 8'h20; mem[10'h304] = 8'h20;
    mem[10'h340] = 8'h41; mem[10'h341] = 8'h42; mem[10'h342] = 8'h43;
    mem[10'h380] = 8'h41; mem[10'h381] = 8'h42; mem[10'h382] = 8'h50;
    mem[10'h383] = 8'h20; mem[10'h384] = 8'h20;
    run_op(1'b1, 8'h20, 'h300, 5, 'h340, 3);
    check("R3 equal with pad", cmp_res, 0);
    check("R3 equal dst_addr", dst_addr, 'h305);
    check("R3 equal src_len", src_len, 0);
    run_op(1'b1, 8'h20, 'h300, 5, 'h380, 5);
    check("R3 low code", cmp_res, 1);
    check("R3 low dst_addr", dst_addr, 'h302);
    check("R3 low dst_len", dst_len, 3);
    check("R3 low src_addr", src_addr, 'h382);
    run_op(1'b1, 8'h10, 'h300, 5, 'h340, 3);
    check("R3 high vs pad", cmp_res, 2);
    check("R3 high dst_addr", dst_addr, 'h303);
    check("R3 high dst_len", dst_len, 2);
    check("R3 high src_addr", src_addr, 'h343);
  endtask

  task automatic t_irq_restart();
    for (int i = 0; i < 12; i++) mem[10'h500 + i] = 8'h00;
    for (int i = 0; i < 10; i++) mem[10'h400 + i] = 8'h80 + 8'(i);
    clear_counts();
    irq_after = 4; irq_en = 1'b1;
    run_op(1'b0, 8'h77, 'h500, 12, 'h400, 10);
    irq_en = 1'b0;
    check("R5 end_kind interrupted", end_kind, 2);
    check("R5 dst_len", dst_len, 8);
    check("R5 dst_addr", dst_addr, 'h504);
    check("R5 src_addr", src_addr, 'h404);
    check("R5 src_len", src_len, 6);
    check("R5 next byte unwritten", mem[10'h504], 0);
    run_op(1'b0, 8'h77, int'(dst_addr), int'(dst_len), int'(src_addr), int'(src_len));
    check("R6 resume end_kind", end_kind, 1);
    for (int i = 0; i < 10; i++) begin
      check("R6 resumed data", mem[10'h500 + i], 8'h80 + i);
      check("R6 single read", rdcnt[10'h400 + i], 1);
    end
    check("R6 resumed pad", mem[10'h50B], 8'h77);
  endtask

  task automatic t_fault();
    for (int i = 0; i < 6; i++) begin
      mem[10'h600 + i] = 8'hC0 + 8'(i);
      mem[10'h700 + i] = 8'hEE;
    end
    fault_en = 1'b1; fault_at = 10'h303 + 10'h400;
    run_op(1'b0, 8'h00, 'h700, 6, 'h600, 6);
    fault_en = 1'b0;
    check("R7 end_kind fault", end_kind, 3);
    check("R7 fault_addr", fault_addr, 'h703);
    check("R7 dst_addr at fault", dst_addr, 'h703);
    check("R7 dst_len at fault", dst_len, 3);
    check("R7 src_len at fault", src_len, 3);
    check("R7 earlier byte done", mem[10'h702], 8'hC2);
    check("R7 faulting byte unwritten", mem[10'h703], 8'hEE);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        hung = 1'b1;
      end
    join_none
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; rdcnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    if (!hung) t_move_pad();
    if (!hung) t_move_long_src();
    if (!hung) t_zero_fill();
    if (!hung) t_zero_len();
    if (!hung) t_compare();
    if (!hung) t_irq_restart();
    if (!hung) t_fault();
    if (hung) check("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule